// File: doc/BRIEF.md
# Retransmit-Capable FIFO with Half-Full and Expansion Output

This block is a single-clock first-in/first-out buffer for 9-bit words, with a depth set by a power-of-two parameter (512 to 16,384 entries in production use). Writes and reads are requested with active-low strobes that are sampled on each rising clock edge. A write is taken only while the buffer is not full. A read is taken only while it is not empty. Full, empty and half-full flags are derived from an occupancy counter that is one bit wider than the address, so a full buffer and an empty buffer are never confused.

An active-low retransmit request moves the read side back to the first location and leaves the write side where it is. Everything written since reset can then be read again, provided fewer than DEPTH words were written. A mode input selects what the shared expansion output carries. In single mode it carries the half-full flag. In chain mode it gives a one-cycle pulse each time a write lands in the last memory location, and retransmit is disabled in that mode. Read data is registered and qualified by a valid bit. When no read was taken, the data output is zero.

Top module: `fifo_rt_hf`

## Requirements
- R1: A synchronous active-low reset leaves the block with empty=1, full=0, half_full=0, xo=0 (in either mode), dout=0 and dout_valid=0, and both pointers at location 0. No write is taken until a reset has been applied.
- R2: A write request (wr_n=0) while full=1 is ignored: the stored contents and the count do not change, so the DEPTH words already held are later read out unchanged and no extra word follows them.
- R3: A read request (rd_n=0) while empty=1 is ignored: dout_valid stays 0, dout stays 0, and the read position does not move.
- R4: full rises after a write that brings the occupancy to DEPTH, which happens on exactly the DEPTH-th write after reset when no reads occur. full is never high together with empty.
- R5: empty is 1 exactly when the occupancy is 0, including after the last stored word has been read.
- R6: Words come out in the order they were written. A read taken at a clock edge presents its word on dout, with dout_valid=1, in the cycle that follows that edge. In every other cycle dout=0 and dout_valid=0.
- R7: half_full is 1 exactly when the occupancy exceeds DEPTH/2. It rises after the write that takes the occupancy from DEPTH/2 to DEPTH/2+1, and it falls after the read that brings the occupancy back to DEPTH/2.
- R8: A retransmit (rt_n=0 with wr_n=1, rd_n=1 and chain_mode=0) sets the read position to location 0 and keeps the write position. The occupancy becomes the number of words written since reset, and all flags follow from that occupancy.
- R9: A retransmit request is ignored when wr_n=0 or rd_n=0 in the same cycle, or when chain_mode=1. Any read or write requested in that cycle is still carried out normally.
- R10: With chain_mode=0, xo equals half_full. With chain_mode=1, xo is 1 for exactly the one cycle after a write is taken into location DEPTH-1, and 0 otherwise.
- R11: A read and a write requested in the same cycle are both taken when neither flag blocks them, and the occupancy is then unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write request, active low |
| rd_n | input | 1 | Read request, active low |
| rt_n | input | 1 | Retransmit request, active low |
| chain_mode | input | 1 | 0: xo carries half-full; 1: xo pulses on the last location, retransmit disabled |
| din | input | 9 | Word to be written |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| half_full | output | 1 | Occupancy exceeds DEPTH/2 |
| xo | output | 1 | Expansion output selected by chain_mode |
| dout | output | 9 | Word read in the previous cycle, otherwise zero |
| dout_valid | output | 1 | dout holds a word read in the previous cycle |

## Verification
The bench builds the block with DEPTH=8, so the half-full threshold is 4 and the last location is 7. With this depth, full, half-full and wrap-around are reached within a handful of cycles. Every starting fill level from 0 to 7 is combined with every number of reads before a retransmit, so every position of the read and write pointers at the moment of a rewind is covered. Long pseudo-random strobe runs in both modes then wrap the pointers many times, and each cycle is checked against an arithmetic occupancy model. These runs cover simultaneous read and write at the empty and full boundaries and each chain-mode pulse on location 7.

// File: rtl/fifo_rt_pkg.sv
// Shared definitions for the retransmit FIFO.
// Assumes: word width is fixed by the system at 9 bits.
package fifo_rt_pkg;
    localparam int WORD_W = 9;

    // Meaning of the expansion output
    typedef enum logic {
        XO_HALF  = 1'b0,
        XO_CHAIN = 1'b1
    } xo_mode_e;

    // True when v is a power of two and at least 4
    function automatic bit depth_ok(input int v);
        return (v >= 4) && ((v & (v - 1)) == 0);
    endfunction
endpackage

// File: rtl/fifo_rt_ptrs.sv
// Pointer and occupancy manager: decides which requests are taken,
// advances the write/read pointers and keeps a DEPTH+1 range count.
// Assumes: a retransmit is only meaningful when fewer than DEPTH words
// were written since reset (count is rebuilt from the write pointer).
module fifo_rt_ptrs
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              rt_req,
    input  xo_mode_e          mode,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              rt_ok,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]  level
);
    localparam logic [CNT_W-1:0]  LVL_FULL = CNT_W'(DEPTH);
    localparam logic [ADDR_W-1:0] PTR_ONE  = ADDR_W'(1);

    logic armed;
    logic at_full;
    logic at_empty;

    // Boundary detection from the stored count
    always_comb begin
        at_full  = (level == LVL_FULL);
        at_empty = (level == '0);
    end

    // Acceptance of each request
    always_comb begin
        wr_ok = wr_req && !at_full && armed;
        rd_ok = rd_req && !at_empty;
        rt_ok = rt_req && !wr_req && !rd_req && (mode == XO_HALF);
    end

    // Writes stay locked until a reset has been seen
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b1;
        else        armed <= armed;
    end

    // Write pointer: advances on every accepted write, wraps at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (wr_ok) wr_ptr <= wr_ptr + PTR_ONE;
    end

    // Read pointer: advances on reads, rewinds on retransmit
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_ptr <= '0;
        else if (rt_ok) rd_ptr <= '0;
        else if (rd_ok) rd_ptr <= rd_ptr + PTR_ONE;
    end

    // Occupancy: net of reads and writes, rebuilt on retransmit
    always_ff @(posedge clk) begin
        if (!rst_n)                level <= '0;
        else if (rt_ok)            level <= {1'b0, wr_ptr};
        else if (wr_ok && !rd_ok)  level <= level + CNT_W'(1);
        else if (rd_ok && !wr_ok)  level <= level - CNT_W'(1);
    end

    initial begin
        if (!depth_ok(DEPTH)) $error("fifo_rt_ptrs: DEPTH must be a power of two >= 4");
    end

    // R2: a write request while full leaves the write pointer in place
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (at_full && wr_req && !rd_req) |=> $stable(wr_ptr));

    // R3: a read request while empty leaves the read pointer in place
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_empty && rd_req) |=> $stable(rd_ptr));

    // R8: retransmit rewinds reading and keeps writing position
    p_rt_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rt_ok |=> (rd_ptr == '0) && $stable(wr_ptr));

    // R9: in chain mode a lone retransmit request changes nothing
    p_rt_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req && !wr_req && !rd_req && mode == XO_CHAIN) |=> $stable(level) && $stable(rd_ptr));

    // R11: simultaneous accepted read and write keep the occupancy
    p_both_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok) |=> $stable(level));
endmodule

// File: rtl/fifo_rt_store.sv
// Word storage and registered read port. Output is zero unless a read
// was taken at the previous edge.
// Assumes: write and read never address the same word in one cycle
// with a meaningful result (read only occurs when not empty).
module fifo_rt_store
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic [ADDR_W-1:0] rd_ptr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_valid
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Storage array write
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= din;
    end

    // Registered read data, cleared when no read is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else if (rd_ok) begin
            dout       <= mem[rd_ptr];
            dout_valid <= 1'b1;
        end else begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end
    end

    // R6: without a valid word the data output is zero
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> (dout == '0));

    // R6: an accepted read yields a valid word one cycle later
    p_valid_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> dout_valid);
endmodule

// File: rtl/fifo_rt_flags.sv
// Flag generator: full/empty/half-full from the occupancy and the
// expansion output, which is half-full or a last-location pulse.
// Assumes: level never exceeds DEPTH.
module fifo_rt_flags
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  level,
    input  logic              wr_ok,
    input  logic              rt_ok,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  xo_mode_e          mode,
    output logic              full,
    output logic              empty,
    output logic              half_full,
    output logic              xo
);
    localparam logic [CNT_W-1:0]  LVL_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0]  LVL_HALF = CNT_W'(DEPTH / 2);
    localparam logic [ADDR_W-1:0] PTR_LAST = ADDR_W'(DEPTH - 1);

    logic last_pulse;

    // Occupancy-derived status flags
    always_comb begin
        full      = (level == LVL_FULL);
        empty     = (level == '0);
        half_full = (level > LVL_HALF);
    end

    // One-cycle marker for a write into the last location
    always_ff @(posedge clk) begin
        if (!rst_n) last_pulse <= 1'b0;
        else        last_pulse <= wr_ok && (wr_ptr == PTR_LAST);
    end

    // Expansion output selection
    always_comb begin
        xo = (mode == XO_CHAIN) ? last_pulse : half_full;
    end

    // R4: full and empty are mutually exclusive
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R7: half-full only rises after a write or a retransmit
    p_hf_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_full) |-> ($past(wr_ok) || $past(rt_ok)));

    // R10: the last-location pulse never lasts two cycles
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        last_pulse |=> !last_pulse);
endmodule

// File: rtl/fifo_rt_hf.sv
// Top of the retransmit FIFO: converts active-low strobes, and joins
// the pointer manager, storage and flag generator.
// Assumes: strobes are synchronous to clk; DEPTH is a power of two.
module fifo_rt_hf
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic              chain_mode,
    input  logic [WORD_W-1:0] din,
    output logic              full,
    output logic              empty,
    output logic              half_full,
    output logic              xo,
    output logic [WORD_W-1:0] dout,
    output logic              dout_valid
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    logic              wr_ok;
    logic              rd_ok;
    logic              rt_ok;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [CNT_W-1:0]  level;
    xo_mode_e          mode;

    // Mode decode
    always_comb mode = xo_mode_e'(chain_mode);

    fifo_rt_ptrs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (!wr_n),
        .rd_req (!rd_n),
        .rt_req (!rt_n),
        .mode   (mode),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .rt_ok  (rt_ok),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .level  (level)
    );

    fifo_rt_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .rd_ok      (rd_ok),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    fifo_rt_flags #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (level),
        .wr_ok     (wr_ok),
        .rt_ok     (rt_ok),
        .wr_ptr    (wr_ptr),
        .mode      (mode),
        .full      (full),
        .empty     (empty),
        .half_full (half_full),
        .xo        (xo)
    );

    // R1: the cycle after reset the block reports empty and idle
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !half_full && !dout_valid));
endmodule

// File: tb/fifo_rt_hf_tb.sv
module fifo_rt_hf_tb;
    localparam int D = 8;
    localparam int H = D / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1, chain_mode = 1'b0;
    logic [8:0] din = '0;
    logic       full, empty, half_full, xo, dout_valid;
    logic [8:0] dout;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [8:0] m_mem [D];
    int m_wp = 0, m_rp = 0, m_cnt = 0;

    fifo_rt_hf #(.DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .chain_mode(chain_mode), .din(din), .full(full), .empty(empty),
        .half_full(half_full), .xo(xo), .dout(dout), .dout_valid(dout_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string ctx, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s): actual %0h expected %0h", req, ctx, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        m_wp = 0; m_rp = 0; m_cnt = 0;
        chk("R1", "reset empty", {8'b0, empty}, 9'd1);
        chk("R1", "reset full", {8'b0, full}, 9'd0);
        chk("R1", "reset half", {8'b0, half_full}, 9'd0);
        chk("R1", "reset xo", {8'b0, xo}, 9'd0);
        chk("R1", "reset dout", dout, 9'd0);
        chk("R1", "reset valid", {8'b0, dout_valid}, 9'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One clock with model update and a full set of output checks
    task automatic cyc(input logic wn, input logic rn, input logic tn, input logic [8:0] d, input string tag);
        logic wr_ok, rd_ok, rt_ok, pulse, e_valid;
        logic [8:0] e_dout;
        @(negedge clk);
        wr_n = wn; rd_n = rn; rt_n = tn; din = d;
        wr_ok = !wn && (m_cnt != D);
        rd_ok = !rn && (m_cnt != 0);
        rt_ok = !tn && wn && rn && !chain_mode;
        e_dout = rd_ok ? m_mem[m_rp] : 9'd0;
        e_valid = rd_ok;
        pulse = chain_mode && wr_ok && (m_wp == D - 1);
        if (rt_ok) begin
            m_rp = 0;
            m_cnt = m_wp;
        end else begin
            if (wr_ok) begin
                m_mem[m_wp] = d;
                m_wp = (m_wp + 1) % D;
            end
            if (rd_ok) m_rp = (m_rp + 1) % D;
            m_cnt = m_cnt + (wr_ok ? 1 : 0) - (rd_ok ? 1 : 0);
        end
        @(posedge clk); #2;
        chk("R4", tag, {8'b0, full}, {8'b0, m_cnt == D});
        chk("R5", tag, {8'b0, empty}, {8'b0, m_cnt == 0});
        chk("R7", tag, {8'b0, half_full}, {8'b0, m_cnt > H});
        chk("R10", tag, {8'b0, xo}, {8'b0, chain_mode ? pulse : (m_cnt > H)});
        chk("R6", tag, dout, e_dout);
        chk("R6", tag, {8'b0, dout_valid}, {8'b0, e_valid});
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog (all requirements): actual expired expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();

        // R3: reads on an empty buffer are ignored
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 9'h1FF, "R3 read while empty");

        // R4/R7: fill to full, flags at every level
        for (int i = 0; i < D; i++) cyc(0, 1, 1, 9'(9'h100 + i * 3), "R4 fill");
        // R2: writes while full are ignored
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 9'h0AA, "R2 write while full");
        // R11: read+write when full: only the read is taken
        cyc(0, 0, 1, 9'h055, "R11 both at full");
        // R6/R5/R7: drain, then one read on empty
        for (int i = 0; i < D + 1; i++) cyc(1, 0, 1, 9'h000, "R5 drain");
        // R11: read+write when empty: only the write is taken
        cyc(0, 0, 1, 9'h077, "R11 both at empty");
        cyc(1, 0, 1, 9'h000, "R11 read back");

        // R8: every fill level and every number of reads before a rewind
        for (int k = 0; k < D; k++) begin
            for (int j = 0; j <= k; j++) begin
                do_reset();
                for (int i = 0; i < k; i++) cyc(0, 1, 1, 9'(k * 32 + j * 4 + i), "R8 load");
                for (int i = 0; i < j; i++) cyc(1, 0, 1, 9'h000, "R8 pre-read");
                cyc(1, 1, 0, 9'h000, "R8 retransmit");
                for (int i = 0; i <= k; i++) cyc(1, 0, 1, 9'h000, "R8 replay");
            end
        end

        // R9: retransmit requests that must be ignored
        do_reset();
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 9'(9'h050 + i), "R9 load");
        cyc(1, 0, 1, 9'h000, "R9 read");
        cyc(1, 0, 0, 9'h000, "R9 rt with read");
        cyc(0, 1, 0, 9'h0F0, "R9 rt with write");
        chain_mode = 1'b1;
        cyc(1, 1, 0, 9'h000, "R9 rt in chain mode");
        chain_mode = 1'b0;
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, 9'h000, "R9 drain");

        // R11/R10: pseudo-random strobes in both modes
        lfsr = 16'hACE1;
        for (int m = 0; m < 2; m++) begin
            chain_mode = logic'(m);
            do_reset();
            for (int i = 0; i < 2500; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cyc(lfsr[0] & lfsr[5], lfsr[3] | (lfsr[7] & lfsr[9]), 1, lfsr[8:0], "R11 random");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule